// File: doc/BRIEF.md
# Flash Bank Operation Status Flags

This block produces the readout of a two-bank NOR-style flash model while an internal program or erase job is running. It watches host write strobes for the unlock command sequences. A four-write sequence starts a byte program and a six-write sequence starts a sector or whole-device erase. From the clock edge that accepts the last write, the block holds a busy state timed by a cycle counter.

While a job runs, reads aimed at the busy bank return a status byte in place of array contents. The status byte carries a polled data bit, a read-toggled bit, a sector-toggled bit and a time-limit flag. Reads aimed at the other bank are served from a small register array, so the two banks work side by side. The host can also hold an erase-pause request. While it is held, the erase timer stops and the sectors outside the erase can be read normally.

All durations are parameters counted in clock cycles. These are the program time, the erase time, the short busy windows for protected targets, and the program time limit.

Top module: `fsg_top`

## Requirements
- R1: Writes of data 0xAA, 0x55, 0xA0 followed by a fourth write (address, data) start a program. The status is visible from the edge that accepts the fourth write. PROG_CYC cycles later the byte reads as its old value ANDed with the written data.
- R2: Writes of 0xAA, 0x55, 0x80, 0xAA, 0x55 followed by 0x30 erase the sector holding that last write's address. Following with 0x10 instead erases every sector. After ERASE_CYC cycles, erased bytes read 0xFF.
- R3: A write whose data does not match the next expected code returns the sequencer to its start, and no job is launched.
- R4: During a program, status bit 7 is the inverse of bit 7 of the data being written. After completion, the read returns the true stored byte.
- R5: During an erase, status bit 7 reads 0. After completion, the erased byte reads 0xFF, so bit 7 reads 1.
- R6: Status bit 6 is 0 on the first status read after each launch and inverts on every later status read that is not paused. Status bits 4, 3, 1 and 0 read 0.
- R7: During an erase, status bit 2 inverts on each read of a sector selected for erase, starting at 0. On any other status read, bit 2 reads 1.
- R8: A program that would need a 0-to-1 bit change never completes. TMO_CYC cycles after launch, status bit 5 becomes 1. A write of 0xF0 then returns the bank to reads, with the array unchanged.
- R9: A program aimed at a protected sector gives status for PROT_PROG_CYC cycles and then returns to reads, with the byte unchanged.
- R10: If every sector selected for erase is protected, status lasts PROT_ERASE_CYC cycles and nothing is erased. In a whole-device erase, protected sectors keep their data.
- R11: The bank is address bit 7. Reads of the bank that is not busy return array data while a job runs.
- R12: While susp_req is high during an unprotected erase, the erase timer stops. In that state, reads of selected sectors show bit 7 = 1, bit 6 held, bit 5 = 0 and bit 2 inverting, and reads of other sectors return array data. The erase resumes when susp_req goes low.
- R13: rdata is 0 after reset. It updates one cycle after a read strobe and holds otherwise. The array resets to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Byte address; top SECT_W bits give the sector, the top bit gives the bank |
| wdata | input | DATA_W | Write data / command code |
| sect_prot | input | 2**SECT_W | Protect flag per sector |
| susp_req | input | 1 | Erase pause request, level sensitive |
| rdata | output | DATA_W | Registered read data or status byte |

## Verification
The hardest state to reach from the ports is a paused erase that still has work left. The bench has to raise the pause request within the erase window, make status reads on both sides of the pause, and then release it. To catch a timer that keeps running, the bench holds the pause for longer than a full erase time. It then expects status to still be present on release, and array data only after the remaining time has run out. The toggle phases across these reads are worked out by counting every status read since launch.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_PGM,
        SQ_E1,
        SQ_E2,
        SQ_E3
    } seq_e;

    localparam logic [7:0] CODE_KEY_A   = 8'hAA;
    localparam logic [7:0] CODE_KEY_B   = 8'h55;
    localparam logic [7:0] CODE_PGM     = 8'hA0;
    localparam logic [7:0] CODE_ERS_ARM = 8'h80;
    localparam logic [7:0] CODE_SECT    = 8'h30;
    localparam logic [7:0] CODE_CHIP    = 8'h10;
    localparam logic [7:0] CODE_ABORT   = 8'hF0;

    localparam int BIT_POLL = 7;
    localparam int BIT_TGL  = 6;
    localparam int BIT_TMO  = 5;
    localparam int BIT_STGL = 2;
endpackage

// File: rtl/fsg_cmd_seq.sv
module fsg_cmd_seq
    import fsg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              go_prog,
    output logic              go_erase,
    output logic              go_chip
);
    typedef struct packed {
        seq_e step;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic [7:0] code;

    assign code = wdata[7:0];

    always_comb begin
        s_d      = s_q;
        go_prog  = 1'b0;
        go_erase = 1'b0;
        go_chip  = 1'b0;
        if (!enable) begin
            s_d.step = SQ_IDLE;
        end else if (wr_en) begin
            s_d.step = SQ_IDLE;
            unique case (s_q.step)
                SQ_IDLE: if (code == CODE_KEY_A) s_d.step = SQ_K1;
                SQ_K1:   if (code == CODE_KEY_B) s_d.step = SQ_K2;
                SQ_K2: begin
                    if (code == CODE_PGM)          s_d.step = SQ_PGM;
                    else if (code == CODE_ERS_ARM) s_d.step = SQ_E1;
                end
                SQ_PGM:  go_prog = 1'b1;
                SQ_E1:   if (code == CODE_KEY_A) s_d.step = SQ_E2;
                SQ_E2:   if (code == CODE_KEY_B) s_d.step = SQ_E3;
                SQ_E3: begin
                    if (code == CODE_SECT) begin
                        go_erase = 1'b1;
                    end else if (code == CODE_CHIP) begin
                        go_erase = 1'b1;
                        go_chip  = 1'b1;
                    end
                end
                default: s_d.step = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.step <= SQ_IDLE;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/fsg_array.sv
module fsg_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SECT_W = 3,
    localparam int NUM_SECT = 1 << SECT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pgm_en,
    input  logic [ADDR_W-1:0]   pgm_addr,
    input  logic [DATA_W-1:0]   pgm_data,
    input  logic                ers_en,
    input  logic [NUM_SECT-1:0] ers_mask,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SHIFT  = ADDR_W - SECT_W;
    localparam int SPAN   = 1 << SHIFT;

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int SI = g / SPAN;
        logic [DATA_W-1:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (ers_en && ers_mask[SI])
                cell_d = '1;
            else if (pgm_en && (pgm_addr == ADDR_W'(g)))
                cell_d = cell_q & pgm_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '1;
            else        cell_q <= cell_d;
        end

        assign cells[g] = cell_q;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/fsg_top.sv
module fsg_top
    import fsg_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 8,
    parameter int SECT_W         = 3,
    parameter int PROG_CYC       = 16,
    parameter int ERASE_CYC      = 64,
    parameter int PROT_PROG_CYC  = 6,
    parameter int PROT_ERASE_CYC = 24,
    parameter int TMO_CYC        = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [(1<<SECT_W)-1:0]   sect_prot,
    input  logic                     susp_req,
    output logic [DATA_W-1:0]        rdata
);
    localparam int NUM_SECT = 1 << SECT_W;
    localparam int MAX_A    = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_B    = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
    localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXC     = (MAX_C > TMO_CYC) ? MAX_C : TMO_CYC;
    localparam int TMR_W    = $clog2(MAXC + 1);

    typedef struct packed {
        op_e                 op;
        logic                prot;
        logic                doom;
        logic                tmo;
        logic [TMR_W-1:0]    tmr;
        logic [ADDR_W-1:0]   paddr;
        logic [DATA_W-1:0]   pdata;
        logic [NUM_SECT-1:0] emask;
        logic [1:0]          banks;
        logic                t6;
        logic                t2;
        logic [DATA_W-1:0]   rdata;
    } st_t;

    st_t s_d, s_q;

    logic                go_prog, go_erase, go_chip;
    logic                busy, susp_act, stat_hit, sect_tgl;
    logic                pgm_en, ers_en;
    logic [DATA_W-1:0]   arr_rd, stat;
    logic [SECT_W-1:0]   sect_rd;
    logic                bank_rd;
    logic [TMR_W-1:0]    limit_m1;
    logic [NUM_SECT-1:0] sel_mask, eff_mask;
    op_e                 op_q;
    logic                tmo_q;
    logic [TMR_W-1:0]    tmr_q;

    assign sect_rd  = addr[ADDR_W-1 -: SECT_W];
    assign bank_rd  = addr[ADDR_W-1];
    assign busy     = (s_q.op != OP_NONE);
    assign susp_act = (s_q.op == OP_ERASE) && !s_q.prot && susp_req;
    assign sect_tgl = (s_q.op == OP_ERASE) && s_q.emask[sect_rd];
    assign stat_hit = busy && s_q.banks[bank_rd] && (!susp_act || s_q.emask[sect_rd]);
    assign op_q     = s_q.op;
    assign tmo_q    = s_q.tmo;
    assign tmr_q    = s_q.tmr;
    assign rdata    = s_q.rdata;

    fsg_cmd_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (!busy),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .go_prog  (go_prog),
        .go_erase (go_erase),
        .go_chip  (go_chip)
    );

    fsg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (pgm_en),
        .pgm_addr (s_q.paddr),
        .pgm_data (s_q.pdata),
        .ers_en   (ers_en),
        .ers_mask (s_q.emask & ~sect_prot),
        .rd_addr  (addr),
        .rd_data  (arr_rd)
    );

    // Length of the running job, minus one
    always_comb begin
        if (s_q.op == OP_PROG)
            limit_m1 = s_q.prot ? TMR_W'(PROT_PROG_CYC - 1) : TMR_W'(PROG_CYC - 1);
        else
            limit_m1 = s_q.prot ? TMR_W'(PROT_ERASE_CYC - 1) : TMR_W'(ERASE_CYC - 1);
    end

    // Status byte presented on a read of the busy bank
    always_comb begin
        stat           = '0;
        stat[BIT_POLL] = susp_act ? 1'b1 : ((s_q.op == OP_PROG) ? ~s_q.pdata[7] : 1'b0);
        stat[BIT_TGL]  = s_q.t6;
        stat[BIT_TMO]  = s_q.tmo;
        stat[BIT_STGL] = sect_tgl ? s_q.t2 : 1'b1;
    end

    assign sel_mask = go_chip ? {NUM_SECT{1'b1}} : (NUM_SECT'(1) << sect_rd);
    assign eff_mask = sel_mask & ~sect_prot;

    always_comb begin
        s_d    = s_q;
        pgm_en = 1'b0;
        ers_en = 1'b0;

        // Job timer
        if (busy && !susp_act && !s_q.tmo) begin
            if (s_q.doom) begin
                if (s_q.tmr == TMR_W'(TMO_CYC - 1)) s_d.tmo = 1'b1;
                else                                s_d.tmr = s_q.tmr + 1'b1;
            end else if (s_q.tmr == limit_m1) begin
                pgm_en  = (s_q.op == OP_PROG)  && !s_q.prot;
                ers_en  = (s_q.op == OP_ERASE) && !s_q.prot;
                s_d.op    = OP_NONE;
                s_d.tmr   = '0;
                s_d.banks = '0;
                s_d.emask = '0;
                s_d.prot  = 1'b0;
            end else begin
                s_d.tmr = s_q.tmr + 1'b1;
            end
        end

        // Leaving a timed-out program
        if (s_q.tmo && wr_en && (wdata[7:0] == CODE_ABORT)) begin
            s_d.op    = OP_NONE;
            s_d.tmo   = 1'b0;
            s_d.doom  = 1'b0;
            s_d.tmr   = '0;
            s_d.banks = '0;
        end

        // Launch
        if (go_prog) begin
            s_d.op    = OP_PROG;
            s_d.paddr = addr;
            s_d.pdata = wdata;
            s_d.prot  = sect_prot[sect_rd];
            s_d.doom  = !sect_prot[sect_rd] && (|(~arr_rd & wdata));
            s_d.tmo   = 1'b0;
            s_d.tmr   = '0;
            s_d.emask = '0;
            s_d.banks = 2'b01 << bank_rd;
            s_d.t6    = 1'b0;
            s_d.t2    = 1'b0;
        end else if (go_erase) begin
            s_d.op    = OP_ERASE;
            s_d.prot  = (eff_mask == '0);
            s_d.doom  = 1'b0;
            s_d.tmo   = 1'b0;
            s_d.tmr   = '0;
            s_d.emask = sel_mask;
            s_d.banks = go_chip ? 2'b11 : (2'b01 << bank_rd);
            s_d.t6    = 1'b0;
            s_d.t2    = 1'b0;
        end

        // Read path
        if (rd_en) begin
            if (stat_hit) begin
                s_d.rdata = stat;
                if (!susp_act) s_d.t6 = ~s_q.t6;
                if (sect_tgl)  s_d.t2 = ~s_q.t2;
            end else begin
                s_d.rdata = arr_rd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.op    <= OP_NONE;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/fsg_chk.sv
module fsg_chk
    import fsg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TMR_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] arr_rd,
    input logic              stat_hit,
    input logic              susp_act,
    input op_e               op_q,
    input logic              tmo_q,
    input logic [TMR_W-1:0]  tmr_q
);
    // R13
    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R11
    a_r11_array_path: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !stat_hit) |=> (rdata == $past(arr_rd)));

    // R5
    a_r5_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && stat_hit && (op_q == OP_ERASE) && !susp_act) |=> !rdata[BIT_POLL]);

    // R8
    a_r8_tmo_only_prog: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> (op_q == OP_PROG));

    // R12
    a_r12_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        susp_act |=> $stable(tmr_q));

    // R6
    a_r6_toggle_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && stat_hit && !susp_act) ##1 (rd_en && stat_hit && !susp_act)
        |=> (rdata[BIT_TGL] != $past(rdata[BIT_TGL])));
endmodule

bind fsg_top fsg_chk #(.DATA_W(DATA_W), .TMR_W(TMR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .arr_rd   (arr_rd),
    .stat_hit (stat_hit),
    .susp_act (susp_act),
    .op_q     (op_q),
    .tmo_q    (tmo_q),
    .tmr_q    (tmr_q)
);

// File: tb/sim_fsg_top.sv
`timescale 1ns/1ps
module sim_fsg_top;
    localparam int PROG_CYC       = 16;
    localparam int ERASE_CYC      = 64;
    localparam int PROT_PROG_CYC  = 6;
    localparam int PROT_ERASE_CYC = 24;
    localparam int TMO_CYC        = 48;

    // {addr, data, first status byte, final byte}
    localparam logic [31:0] VEC [5] = '{
        32'h12_5A_84_5A,
        32'h12_50_84_50,
        32'hA3_81_04_81,
        32'h40_7E_84_7E,
        32'hFF_00_84_00
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] sect_prot = '0;
    logic       susp_req = 1'b0;
    logic [7:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fsg_top #(
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROT_PROG_CYC(PROT_PROG_CYC),
        .PROT_ERASE_CYC(PROT_ERASE_CYC), .TMO_CYC(TMO_CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .sect_prot(sect_prot), .susp_req(susp_req), .rdata(rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prog(input logic [7:0] a, input logic [7:0] d);
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(8'h55, 8'hA0); wr(a, d);
    endtask

    task automatic erase(input logic [7:0] a, input logic [7:0] code);
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(8'h55, 8'h80);
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(a, code);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            finish_run();
        end
    end

    initial begin
        idle(3);
        check("R13 reset rdata", rdata, 8'h00);
        rst_n = 1'b1;
        idle(2);
        rd_chk("R13 array reset value", 8'h10, 8'hFF);

        // Vector table: R1 final data, R4 polled bit
        for (int i = 0; i < 5; i++) begin
            prog(VEC[i][31:24], VEC[i][23:16]);
            rd_chk("R4 program status", VEC[i][31:24], VEC[i][15:8]);
            idle(PROG_CYC + 4);
            rd_chk("R1 programmed byte", VEC[i][31:24], VEC[i][7:0]);
        end

        // R11 other bank, R6 toggle, R13 hold
        prog(8'h13, 8'h11);
        rd_chk("R11 other bank array", 8'h93, 8'hFF);
        rd_chk("R6 first status read", 8'h13, 8'h84);
        rd_chk("R6 second status read", 8'h13, 8'hC4);
        idle(3);
        check("R13 rdata holds", rdata, 8'hC4);
        idle(PROG_CYC + 4);
        rd_chk("R4 true data after program", 8'h13, 8'h11);

        // R8 time limit and abort
        prog(8'h12, 8'hFF);
        idle(TMO_CYC + 8);
        rd_chk("R8 time limit flag", 8'h12, 8'h24);
        wr(8'h00, 8'hF0);
        rd_chk("R8 after abort", 8'h12, 8'h50);

        // R9 protected program
        sect_prot = 8'b0000_0010;
        prog(8'h25, 8'h00);
        rd_chk("R9 protected status", 8'h25, 8'h84);
        idle(PROT_PROG_CYC + 3);
        rd_chk("R9 byte unchanged", 8'h25, 8'hFF);

        // R3 broken sequence
        wr(8'h55, 8'hAA); wr(8'h2A, 8'h55); wr(8'h55, 8'h00); wr(8'h26, 8'h00);
        rd_chk("R3 no launch", 8'h26, 8'hFF);
        sect_prot = 8'h00;

        // R2 R5 R7 sector erase of sector 0
        erase(8'h05, 8'h30);
        rd_chk("R7 sector toggle phase 0", 8'h12, 8'h00);
        rd_chk("R7 sector toggle phase 1", 8'h12, 8'h44);
        rd_chk("R7 unselected sector", 8'h40, 8'h04);
        rd_chk("R11 other bank in erase", 8'h93, 8'hFF);
        idle(ERASE_CYC + 4);
        rd_chk("R5 erased byte", 8'h12, 8'hFF);
        rd_chk("R2 other sector kept", 8'h40, 8'h7E);

        // R12 erase pause
        prog(8'h08, 8'h33);
        idle(PROG_CYC + 4);
        rd_chk("R1 byte before pause test", 8'h08, 8'h33);
        erase(8'h08, 8'h30);
        rd_chk("R12 status before pause", 8'h08, 8'h00);
        susp_req = 1'b1;
        idle(2);
        rd_chk("R12 paused read 1", 8'h08, 8'hC4);
        rd_chk("R12 paused read 2", 8'h08, 8'hC0);
        rd_chk("R12 unselected sector data", 8'h40, 8'h7E);
        idle(ERASE_CYC + 10);
        rd_chk("R12 still paused", 8'h08, 8'hC4);
        susp_req = 1'b0;
        rd_chk("R12 resumed status", 8'h08, 8'h40);
        idle(ERASE_CYC + 4);
        rd_chk("R12 erase completes", 8'h08, 8'hFF);

        // R10 all protected, then partial protection
        sect_prot = 8'hFF;
        erase(8'h00, 8'h10);
        rd_chk("R10 protected erase status", 8'h50, 8'h00);
        idle(PROT_ERASE_CYC + 3);
        rd_chk("R10 nothing erased", 8'h40, 8'h7E);
        sect_prot = 8'b0000_0100;
        erase(8'h00, 8'h10);
        idle(ERASE_CYC + 4);
        rd_chk("R10 protected sector kept", 8'h40, 8'h7E);
        rd_chk("R2 chip erase bank1", 8'hA3, 8'hFF);
        rd_chk("R2 chip erase last byte", 8'hFF, 8'hFF);

        done = 1'b1;
        finish_run();
    end
endmodule